// File: doc/BRIEF.md
# Global Thread Rank Coordinator

This block sits at the centre of a system with several memory controllers. At the end of each scheduling quantum every controller reports how much service it gave each thread during that quantum. The block adds the reports for each thread across all controllers. It then folds the total into a smoothed per-thread history value. Next it orders the threads so that the thread with the least history gets the best rank. Finally it sends that order to every controller. All controllers therefore apply one identical ranking for the whole of the next quantum.

Reports arrive one per cycle. Each report carries a controller index, a thread index and a service amount. A single-cycle quantum-end pulse opens the wait for the remaining reports. The broadcast waits until every controller has reported for every thread. If a report never arrives, a timeout lets the block go ahead and count the missing values as zero. The block works out the ranks over several cycles by counting, for each thread, how many threads sort ahead of it. The thread count, the controller count, the widths, the smoothing weight and the timeout are all parameters.

Top module: `coord_rank_top`

## Requirements
- R1: After reset, every history value is zero, `rank_valid` is low, and the rank field of thread i in `rank_out` (bits `[i*TW +: TW]`, where TW is the thread index width) holds i.
- R2: The service of a thread for a quantum is the sum of the accepted reports for that thread from all controllers. The sum saturates at 2^HIST_W−1 and never wraps.
- R3: At each quantum update, every history value becomes floor((K·old + (2^S−K)·service)/2^S). K is `ALPHA_K` and S is `ALPHA_SH`, so a larger K gives more weight to the past.
- R4: The rank of a thread is the number of threads whose history is smaller, plus the number of threads with an equal history and a lower thread index. Rank 0 is the highest priority, so the ranks always form a permutation.
- R5: `rank_valid` is a single-cycle strobe. `rank_out` changes only in the cycle in which that strobe is high, and it holds its value in every other cycle.
- R6: After a quantum-end pulse, no broadcast is made while any of the CTRLS×THREADS reports is still missing and the timeout has not run out.
- R7: If reports are still missing `TIMEOUT` cycles after the quantum-end pulse, the block proceeds anyway and counts each missing report as zero service.
- R8: A second report from the same controller for the same thread within one quantum is ignored, and the first value is kept.
- R9: A report whose controller index is not below `CTRLS` is ignored.
- R10: Per-quantum sums and received flags are cleared at every update, so service from one quantum never carries into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | A service report is present this cycle |
| rpt_ctrl | input | idx_w(CTRLS) | Index of the reporting controller |
| rpt_thread | input | idx_w(THREADS) | Thread the report refers to |
| rpt_service | input | SVC_W | Service the controller gave that thread in the quantum |
| quantum_end | input | 1 | One-cycle pulse marking the end of a quantum |
| rank_out | output | THREADS*idx_w(THREADS) | Rank of each thread; field i belongs to thread i |
| rank_valid | output | 1 | One-cycle strobe announcing a new ranking |

## Verification
The ranking path is driven with several report patterns. Equal sums for two pairs of threads show whether ties are broken by the lower index. A thread whose reports add up past the history range shows whether the sum saturates or wraps, because a wrapped sum would move that thread ahead of another thread. Two quanta in a row with opposite heavy threads show the weight given to the past, and they also show whether the previous sums were cleared. Withheld reports show that the block waits and that the timeout fires. Repeated reports and reports with an out-of-range controller index show that these reports leave the ranking unchanged.

// File: rtl/coord_pkg.sv
`timescale 1ns/1ps
package coord_pkg;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_WAIT,
    ST_UPDATE,
    ST_RANK,
    ST_SEND
  } crd_state_e;

  // index width that stays legal for a count of one
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic logic [63:0] sat_add(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input logic [63:0] limit);
    logic [63:0] s;
    s = a + b;
    return (s > limit) ? limit : s;
  endfunction

  // weighted blend: (k*old + (2^sh-k)*cur) >> sh, built from one multiply
  // applied to the distance between the two operands
  function automatic logic [63:0] blend(input logic [63:0] old_v,
                                        input logic [63:0] cur_v,
                                        input int          k,
                                        input int          sh);
    logic [63:0] base;
    logic [63:0] span;
    logic [63:0] w;
    base = cur_v << sh;
    if (old_v >= cur_v) begin
      span = old_v - cur_v;
      w    = base + 64'(k) * span;
    end else begin
      span = cur_v - old_v;
      w    = base - 64'(k) * span;
    end
    return w >> sh;
  endfunction

  // true when (ka, ia) sorts ahead of (kb, ib)
  function automatic logic sorts_ahead(input logic [63:0] ka, input int ia,
                                       input logic [63:0] kb, input int ib);
    return (ka < kb) || ((ka == kb) && (ia < ib));
  endfunction

endpackage

// File: rtl/coord_svc_accum.sv
`timescale 1ns/1ps
module coord_svc_accum import coord_pkg::*; #(
  parameter int THREADS = 4,
  parameter int CTRLS   = 3,
  parameter int SVC_W   = 12,
  parameter int HIST_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic                         clear,
  input  logic                         rpt_valid,
  input  logic [idx_w(CTRLS)-1:0]      rpt_ctrl,
  input  logic [idx_w(THREADS)-1:0]    rpt_thread,
  input  logic [SVC_W-1:0]             rpt_service,
  output logic [THREADS*HIST_W-1:0]    svc_flat,
  output logic                         all_rcvd,
  output logic                         take
);
  localparam int          SLOTS   = THREADS * CTRLS;
  localparam logic [63:0] SUM_MAX = (64'(1) << HIST_W) - 64'(1);

  logic [SLOTS-1:0]  seen_q;
  logic [HIST_W-1:0] sum_q [THREADS];
  logic              id_ok;
  int                slot;

  always_comb begin
    id_ok = (int'(rpt_ctrl) < CTRLS) && (int'(rpt_thread) < THREADS);
    slot  = id_ok ? (int'(rpt_ctrl) * THREADS + int'(rpt_thread)) : 0;
    take  = accept && rpt_valid && id_ok && !seen_q[slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      seen_q <= '0;
      for (int t = 0; t < THREADS; t++) sum_q[t] <= '0;
    end else if (take) begin
      seen_q[slot] <= 1'b1;
      for (int t = 0; t < THREADS; t++) begin
        if (int'(rpt_thread) == t)
          sum_q[t] <= HIST_W'(sat_add(64'(sum_q[t]), 64'(rpt_service), SUM_MAX));
      end
    end
  end

  assign all_rcvd = &seen_q;

  for (genvar t = 0; t < THREADS; t++) begin : g_flat
    assign svc_flat[t*HIST_W +: HIST_W] = sum_q[t];
  end

endmodule

// File: rtl/coord_hist.sv
`timescale 1ns/1ps
module coord_hist import coord_pkg::*; #(
  parameter int THREADS  = 4,
  parameter int HIST_W   = 16,
  parameter int ALPHA_K  = 3,
  parameter int ALPHA_SH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [THREADS*HIST_W-1:0] svc_flat,
  output logic [THREADS*HIST_W-1:0] hist_flat
);
  localparam logic [63:0] H_MAX = (64'(1) << HIST_W) - 64'(1);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [HIST_W-1:0] h_q;
    logic [63:0]       nxt;

    always_comb begin
      nxt = blend(64'(h_q), 64'(svc_flat[t*HIST_W +: HIST_W]), ALPHA_K, ALPHA_SH);
      if (nxt > H_MAX) nxt = H_MAX;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    h_q <= '0;
      else if (load) h_q <= HIST_W'(nxt);
    end

    assign hist_flat[t*HIST_W +: HIST_W] = h_q;
  end

endmodule

// File: rtl/coord_rank_sort.sv
`timescale 1ns/1ps
module coord_rank_sort import coord_pkg::*; #(
  parameter int THREADS = 4,
  parameter int HIST_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [THREADS*HIST_W-1:0]         keys_flat,
  output logic [THREADS*idx_w(THREADS)-1:0] cnt_flat,
  output logic                              done
);
  localparam int TW = idx_w(THREADS);

  logic [HIST_W-1:0] key [THREADS];
  logic [TW-1:0]     cnt_q [THREADS];
  logic [TW-1:0]     idx_q;
  logic              busy_q;

  for (genvar t = 0; t < THREADS; t++) begin : g_io
    assign key[t]                 = keys_flat[t*HIST_W +: HIST_W];
    assign cnt_flat[t*TW +: TW]   = cnt_q[t];
  end

  // one probe thread per cycle is compared against all threads at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done   <= 1'b0;
      idx_q  <= '0;
      for (int t = 0; t < THREADS; t++) cnt_q[t] <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      done   <= 1'b0;
      idx_q  <= '0;
      for (int t = 0; t < THREADS; t++) cnt_q[t] <= '0;
    end else if (busy_q) begin
      for (int t = 0; t < THREADS; t++) begin
        if (sorts_ahead(64'(key[idx_q]), int'(idx_q), 64'(key[t]), t))
          cnt_q[t] <= cnt_q[t] + TW'(1);
      end
      if (int'(idx_q) == THREADS - 1) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end else begin
        idx_q <= idx_q + TW'(1);
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/coord_rank_top.sv
`timescale 1ns/1ps
module coord_rank_top import coord_pkg::*; #(
  parameter int THREADS  = 4,
  parameter int CTRLS    = 3,
  parameter int SVC_W    = 12,
  parameter int HIST_W   = 16,
  parameter int ALPHA_K  = 3,
  parameter int ALPHA_SH = 2,
  parameter int TIMEOUT  = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rpt_valid,
  input  logic [idx_w(CTRLS)-1:0]           rpt_ctrl,
  input  logic [idx_w(THREADS)-1:0]         rpt_thread,
  input  logic [SVC_W-1:0]                  rpt_service,
  input  logic                              quantum_end,
  output logic [THREADS*idx_w(THREADS)-1:0] rank_out,
  output logic                              rank_valid
);
  localparam int TW  = idx_w(THREADS);
  localparam int TMW = idx_w(TIMEOUT + 1);

  crd_state_e state_q;
  logic [TMW-1:0] tmr_q;

  // named internal events
  logic accept_win, in_wait, all_rcvd, tmo_hit, hist_load, sort_done, take;
  logic [THREADS*HIST_W-1:0] svc_flat, hist_flat;
  logic [THREADS*TW-1:0]     cnt_flat;

  assign accept_win = (state_q == ST_COLLECT) || (state_q == ST_WAIT);
  assign in_wait    = (state_q == ST_WAIT);
  assign tmo_hit    = in_wait && (int'(tmr_q) >= TIMEOUT - 1);
  assign hist_load  = (state_q == ST_UPDATE);

  coord_svc_accum #(
    .THREADS(THREADS), .CTRLS(CTRLS), .SVC_W(SVC_W), .HIST_W(HIST_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .accept(accept_win), .clear(hist_load),
    .rpt_valid(rpt_valid), .rpt_ctrl(rpt_ctrl), .rpt_thread(rpt_thread),
    .rpt_service(rpt_service), .svc_flat(svc_flat), .all_rcvd(all_rcvd),
    .take(take)
  );

  coord_hist #(
    .THREADS(THREADS), .HIST_W(HIST_W), .ALPHA_K(ALPHA_K), .ALPHA_SH(ALPHA_SH)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .load(hist_load), .svc_flat(svc_flat),
    .hist_flat(hist_flat)
  );

  coord_rank_sort #(
    .THREADS(THREADS), .HIST_W(HIST_W)
  ) u_sort (
    .clk(clk), .rst_n(rst_n), .start(hist_load), .keys_flat(hist_flat),
    .cnt_flat(cnt_flat), .done(sort_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (quantum_end) begin
          state_q <= ST_WAIT;
          tmr_q   <= '0;
        end
        ST_WAIT: begin
          if (all_rcvd || tmo_hit) state_q <= ST_UPDATE;
          else                     tmr_q   <= tmr_q + TMW'(1);
        end
        ST_UPDATE: state_q <= ST_RANK;
        ST_RANK:   if (sort_done) state_q <= ST_SEND;
        ST_SEND:   state_q <= ST_COLLECT;
        default:   state_q <= ST_COLLECT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) rank_out[t*TW +: TW] <= TW'(t);
    end else if (state_q == ST_RANK && sort_done) begin
      rank_out <= cnt_flat;
    end
  end

  assign rank_valid = (state_q == ST_SEND);

endmodule

// File: rtl/coord_rank_chk.sv
`timescale 1ns/1ps
module coord_rank_chk import coord_pkg::*; #(
  parameter int THREADS = 4,
  parameter int HIST_W  = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              rank_valid,
  input logic [THREADS*idx_w(THREADS)-1:0] rank_out,
  input logic [THREADS*HIST_W-1:0]         hist_flat,
  input logic                              in_wait,
  input logic                              all_rcvd,
  input logic                              tmo_hit,
  input logic                              hist_load
);
  localparam int TW = idx_w(THREADS);

  logic [(1<<TW)-1:0] used;
  always_comb begin
    used = '0;
    for (int t = 0; t < THREADS; t++) used[rank_out[t*TW +: TW]] = 1'b1;
  end

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rank_valid |=> !rank_valid) else $error("strobe longer than one cycle"); // R5

  AST_RANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_out != $past(rank_out)) |-> rank_valid) else $error("rank moved without strobe"); // R5

  AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rank_valid |-> ($countones(used) == THREADS)) else $error("ranks not a permutation"); // R4

  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !all_rcvd && !tmo_hit) |=> in_wait) else $error("left wait early"); // R6

  AST_HIST_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_load |=> $stable(hist_flat)) else $error("history moved outside update"); // R3

  for (genvar i = 0; i < THREADS; i++) begin : g_i
    for (genvar j = 0; j < THREADS; j++) begin : g_j
      if (i != j) begin : g_pair
        AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
          (rank_valid && (hist_flat[i*HIST_W +: HIST_W] < hist_flat[j*HIST_W +: HIST_W]))
          |-> (rank_out[i*TW +: TW] < rank_out[j*TW +: TW])) else $error("order broken"); // R4
      end
    end
  end

endmodule

bind coord_rank_top coord_rank_chk #(.THREADS(THREADS), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rank_valid(rank_valid), .rank_out(rank_out),
  .hist_flat(hist_flat), .in_wait(in_wait), .all_rcvd(all_rcvd),
  .tmo_hit(tmo_hit), .hist_load(hist_load)
);

// File: tb/tb_coord_rank_top.sv
`timescale 1ns/1ps
module tb_coord_rank_top;
  localparam int T   = 4;
  localparam int C   = 3;
  localparam int SW  = 12;
  localparam int HW  = 13;
  localparam int K   = 3;
  localparam int SH  = 2;
  localparam int TMO = 40;
  localparam longint HMAX = (64'd1 << HW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rpt_valid = 1'b0;
  logic [1:0] rpt_ctrl = '0;
  logic [1:0] rpt_thread = '0;
  logic [SW-1:0] rpt_service = '0;
  logic quantum_end = 1'b0;
  logic [T*2-1:0] rank_out;
  logic rank_valid;

  always #2.5 clk = ~clk;

  coord_rank_top #(
    .THREADS(T), .CTRLS(C), .SVC_W(SW), .HIST_W(HW),
    .ALPHA_K(K), .ALPHA_SH(SH), .TIMEOUT(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_ctrl(rpt_ctrl),
    .rpt_thread(rpt_thread), .rpt_service(rpt_service),
    .quantum_end(quantum_end), .rank_out(rank_out), .rank_valid(rank_valid)
  );

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int rv [C][T];
  bit pr [C][T];
  longint hm [T];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_plan(input int base, input int step);
    for (int c = 0; c < C; c++)
      for (int t = 0; t < T; t++) begin
        rv[c][t] = base + step * t;
        pr[c][t] = 1'b1;
      end
  endtask

  task automatic send_rpt(input int c, input int t, input int v);
    rpt_valid   = 1'b1;
    rpt_ctrl    = 2'(c);
    rpt_thread  = 2'(t);
    rpt_service = SW'(v);
    @(negedge clk);
    rpt_valid   = 1'b0;
  endtask

  task automatic send_plan();
    for (int c = 0; c < C; c++)
      for (int t = 0; t < T; t++)
        if (pr[c][t]) send_rpt(c, t, rv[c][t]);
  endtask

  task automatic pulse_qend();
    quantum_end = 1'b1;
    @(negedge clk);
    quantum_end = 1'b0;
  endtask

  task automatic wait_bcast(output int n, output bit got);
    got = 1'b0;
    n = 0;
    while (!got && n < 400) begin
      @(negedge clk);
      n++;
      if (rank_valid) got = 1'b1;
    end
  endtask

  // reference model: sums only reports marked present, weighted history,
  // rank by counting the threads that sort ahead
  task automatic model_check(input string tag, input bit got);
    longint s;
    int er;
    logic [T*2-1:0] snap;
    chk(got, {tag, " R5 broadcast seen"}, got, 1);
    for (int t = 0; t < T; t++) begin
      s = 0;
      for (int c = 0; c < C; c++) if (pr[c][t]) s += rv[c][t];
      if (s > HMAX) s = HMAX;
      hm[t] = (K * hm[t] + ((1 << SH) - K) * s) / (1 << SH);
    end
    for (int i = 0; i < T; i++) begin
      er = 0;
      for (int j = 0; j < T; j++)
        if (hm[j] < hm[i] || (hm[j] == hm[i] && j < i)) er++;
      chk(int'(rank_out[i*2 +: 2]) == er, {tag, " R4 rank"}, rank_out[i*2 +: 2], er);
    end
    snap = rank_out;
    @(negedge clk);
    chk(rank_valid == 1'b0, {tag, " R5 strobe one cycle"}, rank_valid, 0);
    repeat (3) @(negedge clk);
    chk(rank_out == snap, {tag, " R5 rank held"}, rank_out, snap);
  endtask

  task automatic run_full(input string tag);
    int n;
    bit got;
    send_plan();
    pulse_qend();
    wait_bcast(n, got);
    model_check(tag, got);
  endtask

  task automatic test_reset();
    for (int i = 0; i < T; i++)
      chk(int'(rank_out[i*2 +: 2]) == i, "R1 reset rank identity", rank_out[i*2 +: 2], i);
    chk(rank_valid == 1'b0, "R1 reset strobe low", rank_valid, 0);
  endtask

  task automatic test_ties();
    set_plan(0, 0);
    rv[0][0] = 400;
    rv[0][3] = 400;
    run_full("ties");
  endtask

  task automatic test_sat();
    set_plan(0, 0);
    for (int c = 0; c < C; c++) begin
      rv[c][1] = 2000;
      rv[c][2] = 4095;
      rv[c][3] = 100;
    end
    run_full("R2 saturation");
  endtask

  task automatic test_history();
    set_plan(0, 0);
    for (int c = 0; c < C; c++) rv[c][0] = 2000;
    run_full("R3 quantum A");
    set_plan(0, 0);
    for (int c = 0; c < C; c++) rv[c][3] = 1500;
    run_full("R3 R10 quantum B");
  endtask

  task automatic test_wait_all();
    int n;
    bit got;
    bit early;
    set_plan(100, 100);
    for (int c = 0; c < C; c++) rv[c][1] = 37 + c;
    pr[2][3] = 1'b0;
    send_plan();
    pulse_qend();
    early = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (rank_valid) early = 1'b1;
    end
    chk(!early, "R6 held while report missing", early, 0);
    pr[2][3] = 1'b1;
    send_rpt(2, 3, rv[2][3]);
    wait_bcast(n, got);
    chk(n < TMO, "R6 sent once all reports in", n, TMO);
    model_check("R6", got);
  endtask

  task automatic test_timeout();
    int n;
    bit got;
    set_plan(500, 0);
    for (int c = 0; c < C; c++) rv[c][0] = 3000;
    for (int t = 0; t < T; t++) pr[1][t] = 1'b0;
    send_plan();
    pulse_qend();
    wait_bcast(n, got);
    chk(n >= TMO, "R7 timeout delay", n, TMO);
    model_check("R7", got);
  endtask

  task automatic test_dup();
    set_plan(50, 300);
    send_plan();
    send_rpt(0, 0, 4000);
    pr[0][0] = 1'b0;
    pr[0][0] = 1'b1;
    pulse_qend();
    begin
      int n;
      bit got;
      wait_bcast(n, got);
      model_check("R8 duplicate", got);
    end
  endtask

  task automatic test_badctrl();
    int n;
    bit got;
    set_plan(200, 0);
    send_rpt(3, 1, 4000);
    send_plan();
    pulse_qend();
    wait_bcast(n, got);
    model_check("R9 bad controller", got);
  endtask

  initial begin
    for (int t = 0; t < T; t++) hm[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_ties();
    test_sat();
    test_history();
    test_wait_all();
    test_timeout();
    test_dup();
    test_badctrl();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule